// File: doc/BRIEF.md
# Power-Guarded Record Write Sequencer

This block stands between a requester and a byte-wide nonvolatile memory that needs several cycles to program each cell. It writes and reads multi-byte records. Each record has a flag cell at its base address and a payload of 1 to 8 bytes in the cells just above it. On a write, the flag is first set to the invalid code, then the payload is programmed, and the flag is set to the valid code only at the very end. A record cut short by a power loss therefore always reads back as invalid. A read returns the payload bytes together with the state of the flag, so the requester can throw away a record that is only partly written.

Before every cell write the sequencer checks the power-fail warning input, and it does not start the write while that input is high. If the warning comes partway through a record, the cell already being programmed is allowed to finish, and then the sequence stops. Before every memory access it also waits until the memory's busy flag is low. While a cell is being programmed it raises a reset hold-off request, which is limited to a fixed number of cycles so that a hung sequence cannot hold reset off for ever. Whenever the sequencer is idle, the memory address is parked on the highest cell, which holds no data, so a stray write strobe cannot damage a record.

The requester raises `req_start` for one cycle while `req_busy` is low. For a write, it then supplies the payload bytes one at a time on a valid/ready pair. The end of every operation is marked by a one-cycle `done` pulse that carries a status code.

Top module: `nvr_guard_seq`

## Requirements
- R1: If `pfail` is high when the first cell of a write record is due, no write strobe is issued at all. `done` then reports status 2'b10 (refused).
- R2: A successful write with base B and N payload bytes issues exactly N+2 strobes, in this order:
  - B with data 8'h00 (invalid code);
  - B+1 to B+N with the payload bytes, in the order they were handed over;
  - B with data 8'hA5 (valid code).
  `done` then reports status 2'b00.
- R3: If `pfail` rises after the first strobe of a write, the cell being programmed finishes and no further strobe is issued. The flag cell keeps 8'h00, and `done` reports status 2'b01 (aborted).
- R4: `mem_we` is never high in a cycle that directly follows a cycle in which `pfail` was high.
- R5: `nores` is high in every cycle in which `mem_we` is high, and in every following cycle up to and including the first cycle in which `mem_busy` is low. It is low in the cycle after that.
- R6: `nores` is never high for more than HOLD_LIMIT (default 16) consecutive cycles, even if the memory stays busy for longer.
- R7: Whenever `req_busy` is low, `mem_addr` equals the parking cell, which is all ones (63 with the defaults).
- R8: Neither `mem_we` nor `mem_re` is ever high while `mem_busy` is high. A start request made while the memory is busy waits for it.
- R9: A read of base B and N bytes presents the N cells B+1 to B+N, in that order, on `out_valid`/`out_data`. With the `done` pulse, `rd_flag_ok` is 1 only if cell B holds 8'hA5.
- R10: `req_len` carries the payload length minus one, so 0 means 1 byte and 7 means 8 bytes.
- R11: `done` is a single-cycle pulse. A `req_start` made while `req_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start pulse, taken only while idle |
| req_rd | input | 1 | 1 = read record, 0 = write record |
| req_base | input | AW | Flag cell address of the record |
| req_len | input | LENW | Payload length minus one |
| req_busy | output | 1 | An operation is in progress |
| in_valid | input | 1 | Write payload byte is present |
| in_data | input | DW | Write payload byte |
| in_ready | output | 1 | Payload byte is taken at this edge |
| out_valid | output | 1 | Read payload byte is present |
| out_data | output | DW | Read payload byte |
| done | output | 1 | Operation finished (one cycle) |
| done_status | output | 2 | 00 ok, 01 aborted, 10 refused |
| rd_flag_ok | output | 1 | Read found a valid flag (meaningful with done) |
| pfail | input | 1 | Power-fail warning |
| nores | output | 1 | Request to hold off reset |
| mem_addr | output | AW | Memory cell address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write strobe (one cycle per cell) |
| mem_re | output | 1 | Memory read strobe, data one cycle later |
| mem_rdata | input | DW | Memory read data |
| mem_busy | input | 1 | Memory is programming a cell |

## Verification
The hardest case to reach from the ports is a power warning that lands in the middle of a record, after the flag has been cleared but before it has been set. The bench arms a trigger that counts write strobes and raises `pfail` just after the second strobe. That strobe's cell is still programming when the warning arrives. The bench then checks the abort status, the exact number of strobes and the contents left in the cells, and reads the record back to confirm it reports invalid. It also holds the memory busy on its own before a start, and stretches one programming time past the hold-off limit, so that the busy wait and the hold-off cap are both exercised.

// File: rtl/nvr_pkg.sv
package nvr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_STRB,
    ST_WAIT,
    ST_RSTRB,
    ST_RCAP,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    CK_FLAG0,
    CK_DATA,
    CK_FLAG1
  } cell_kind_t;

  typedef enum logic [1:0] {
    RS_OK     = 2'b00,
    RS_ABORT  = 2'b01,
    RS_REFUSE = 2'b10
  } rec_status_t;

endpackage

// File: rtl/nvr_holdoff.sv
module nvr_holdoff #(
  parameter int HOLD_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  output logic nores
);

  localparam int CW = $clog2(HOLD_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_LIMIT);

  logic          hold_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (hold_q && hold_req) begin
      cnt_n = (cnt_q == LIMIT) ? cnt_q : cnt_q + CW'(1);
    end else begin
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      hold_q <= hold_req;
      cnt_q  <= cnt_n;
    end
  end

  assign nores = hold_q && (cnt_q < LIMIT);

endmodule

// File: rtl/nvr_addr_gen.sv
module nvr_addr_gen
  import nvr_pkg::*;
#(
  parameter int AW   = 6,
  parameter int LENW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic [AW-1:0]   req_base,
  input  cell_kind_t      kind,
  input  logic [LENW-1:0] idx,
  input  logic            active,
  output logic [AW-1:0]   mem_addr
);

  localparam logic [AW-1:0] PARK = {AW{1'b1}};

  logic [AW-1:0] base_q;
  logic [AW-1:0] offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (accept) begin
      base_q <= req_base;
    end
  end

  always_comb begin
    if (kind == CK_DATA) begin
      offset = AW'(idx) + AW'(1);
    end else begin
      offset = '0;
    end
  end

  assign mem_addr = active ? (base_q + offset) : PARK;

endmodule

// File: rtl/nvr_seq_ctrl.sv
module nvr_seq_ctrl
  import nvr_pkg::*;
#(
  parameter int            DW           = 8,
  parameter int            LENW         = 3,
  parameter logic [DW-1:0] VALID_CODE   = 8'hA5,
  parameter logic [DW-1:0] INVALID_CODE = 8'h00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic            req_rd,
  input  logic [LENW-1:0] req_len,
  input  logic            pfail,
  input  logic            mem_busy,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  input  logic [DW-1:0]   mem_rdata,
  output logic            accept,
  output seq_state_t      state_o,
  output cell_kind_t      kind_o,
  output logic [LENW-1:0] idx_o,
  output logic            in_ready,
  output logic            mem_we,
  output logic            mem_re,
  output logic [DW-1:0]   mem_wdata,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic            done,
  output logic [1:0]      done_status,
  output logic            rd_flag_ok,
  output logic            busy,
  output logic            hold_next
);

  seq_state_t      state_q, state_n;
  cell_kind_t      kind_q, kind_n;
  logic [LENW-1:0] idx_q, idx_n;
  logic [LENW-1:0] len_q, len_n;
  logic            rd_q, rd_n;
  logic [DW-1:0]   wdata_q, wdata_n;
  rec_status_t     status_q, status_n;
  logic            flag_q, flag_n;
  logic            wrote_q, wrote_n;
  logic            ov_q, ov_n;
  logic [DW-1:0]   od_q, od_n;

  cell_kind_t      adv_kind;
  logic [LENW-1:0] adv_idx;
  logic            adv_fin;

  // Which cell follows the current one, and whether the record is finished.
  always_comb begin
    adv_kind = kind_q;
    adv_idx  = idx_q;
    adv_fin  = 1'b0;
    unique case (kind_q)
      CK_FLAG0: begin
        adv_kind = CK_DATA;
        adv_idx  = '0;
      end
      CK_DATA: begin
        if (idx_q == len_q) begin
          if (rd_q) begin
            adv_fin = 1'b1;
          end else begin
            adv_kind = CK_FLAG1;
          end
        end else begin
          adv_idx = idx_q + LENW'(1);
        end
      end
      default: adv_fin = 1'b1;
    endcase
  end

  always_comb begin
    state_n  = state_q;
    kind_n   = kind_q;
    idx_n    = idx_q;
    len_n    = len_q;
    rd_n     = rd_q;
    wdata_n  = wdata_q;
    status_n = status_q;
    flag_n   = flag_q;
    wrote_n  = wrote_q;
    ov_n     = 1'b0;
    od_n     = od_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_start) begin
          state_n  = ST_PREP;
          kind_n   = CK_FLAG0;
          idx_n    = '0;
          len_n    = req_len;
          rd_n     = req_rd;
          status_n = RS_OK;
          flag_n   = 1'b0;
          wrote_n  = 1'b0;
        end
      end
      ST_PREP: begin
        if (!mem_busy) begin
          if (rd_q) begin
            state_n = ST_RSTRB;
          end else if (pfail) begin
            status_n = wrote_q ? RS_ABORT : RS_REFUSE;
            state_n  = ST_DONE;
          end else if (kind_q != CK_DATA) begin
            wdata_n = (kind_q == CK_FLAG0) ? INVALID_CODE : VALID_CODE;
            state_n = ST_STRB;
          end else if (in_valid) begin
            wdata_n = in_data;
            state_n = ST_STRB;
          end
        end
      end
      ST_STRB: begin
        wrote_n = 1'b1;
        state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (!mem_busy) begin
          if (adv_fin) begin
            state_n  = ST_DONE;
            status_n = RS_OK;
          end else begin
            state_n = ST_PREP;
            kind_n  = adv_kind;
            idx_n   = adv_idx;
          end
        end
      end
      ST_RSTRB: begin
        state_n = ST_RCAP;
      end
      ST_RCAP: begin
        if (kind_q == CK_FLAG0) begin
          flag_n = (mem_rdata == VALID_CODE);
        end else begin
          ov_n = 1'b1;
          od_n = mem_rdata;
        end
        if (adv_fin) begin
          state_n  = ST_DONE;
          status_n = RS_OK;
        end else begin
          state_n = ST_PREP;
          kind_n  = adv_kind;
          idx_n   = adv_idx;
        end
      end
      ST_DONE: begin
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= CK_FLAG0;
      idx_q    <= '0;
      len_q    <= '0;
      rd_q     <= 1'b0;
      wdata_q  <= '0;
      status_q <= RS_OK;
      flag_q   <= 1'b0;
      wrote_q  <= 1'b0;
      ov_q     <= 1'b0;
      od_q     <= '0;
    end else begin
      state_q  <= state_n;
      kind_q   <= kind_n;
      idx_q    <= idx_n;
      len_q    <= len_n;
      rd_q     <= rd_n;
      wdata_q  <= wdata_n;
      status_q <= status_n;
      flag_q   <= flag_n;
      wrote_q  <= wrote_n;
      ov_q     <= ov_n;
      od_q     <= od_n;
    end
  end

  assign accept      = (state_q == ST_IDLE) && req_start;
  assign state_o     = state_q;
  assign kind_o      = kind_q;
  assign idx_o       = idx_q;
  assign in_ready    = (state_q == ST_PREP) && !rd_q && (kind_q == CK_DATA) &&
                       !mem_busy && !pfail;
  assign mem_we      = (state_q == ST_STRB);
  assign mem_re      = (state_q == ST_RSTRB);
  assign mem_wdata   = wdata_q;
  assign out_valid   = ov_q;
  assign out_data    = od_q;
  assign done        = (state_q == ST_DONE);
  assign done_status = status_q;
  assign rd_flag_ok  = flag_q;
  assign busy        = (state_q != ST_IDLE);
  assign hold_next   = (state_n == ST_STRB) || (state_n == ST_WAIT);

endmodule

// File: rtl/nvr_guard_seq.sv
module nvr_guard_seq
  import nvr_pkg::*;
#(
  parameter int            AW           = 6,
  parameter int            DW           = 8,
  parameter int            MAX_LEN      = 8,
  parameter int            HOLD_LIMIT   = 16,
  parameter logic [DW-1:0] VALID_CODE   = 8'hA5,
  parameter logic [DW-1:0] INVALID_CODE = 8'h00,
  localparam int           LENW         = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_start,
  input  logic            req_rd,
  input  logic [AW-1:0]   req_base,
  input  logic [LENW-1:0] req_len,
  output logic            req_busy,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic            done,
  output logic [1:0]      done_status,
  output logic            rd_flag_ok,
  input  logic            pfail,
  output logic            nores,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_busy
);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_core_n = rs_q[1];

  logic            accept;
  seq_state_t      st;
  cell_kind_t      kind;
  logic [LENW-1:0] idx;
  logic            hold_next;
  logic            active;

  nvr_seq_ctrl #(
    .DW(DW), .LENW(LENW), .VALID_CODE(VALID_CODE), .INVALID_CODE(INVALID_CODE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_core_n),
    .req_start(req_start), .req_rd(req_rd), .req_len(req_len),
    .pfail(pfail), .mem_busy(mem_busy), .in_valid(in_valid), .in_data(in_data),
    .mem_rdata(mem_rdata), .accept(accept), .state_o(st), .kind_o(kind),
    .idx_o(idx), .in_ready(in_ready), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .out_valid(out_valid), .out_data(out_data),
    .done(done), .done_status(done_status), .rd_flag_ok(rd_flag_ok),
    .busy(req_busy), .hold_next(hold_next)
  );

  assign active = (st == ST_STRB) || (st == ST_WAIT) ||
                  (st == ST_RSTRB) || (st == ST_RCAP);

  nvr_addr_gen #(.AW(AW), .LENW(LENW)) u_addr (
    .clk(clk), .rst_n(rst_core_n), .accept(accept), .req_base(req_base),
    .kind(kind), .idx(idx), .active(active), .mem_addr(mem_addr)
  );

  nvr_holdoff #(.HOLD_LIMIT(HOLD_LIMIT)) u_hold (
    .clk(clk), .rst_n(rst_core_n), .hold_req(hold_next), .nores(nores)
  );

endmodule

// File: rtl/nvr_guard_seq_chk.sv
module nvr_guard_seq_chk #(
  parameter int AW         = 6,
  parameter int HOLD_LIMIT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pfail,
  input logic          mem_we,
  input logic          mem_re,
  input logic          mem_busy,
  input logic          nores,
  input logic          req_busy,
  input logic [AW-1:0] mem_addr,
  input logic          done
);

  localparam int RW = $clog2(HOLD_LIMIT + 2);
  localparam logic [RW-1:0] CAP = RW'(HOLD_LIMIT + 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (nores) begin
      run_q <= (run_q == CAP) ? run_q : run_q + RW'(1);
    end else begin
      run_q <= '0;
    end
  end

  // R4
  pfail_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !$past(pfail));

  // R8
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !mem_busy);

  // R8
  re_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> !mem_busy);

  // R7
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_busy |-> (mem_addr == {AW{1'b1}}));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  hold_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> nores);

  // R5
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nores && !mem_busy && !mem_we) |=> !nores);

  // R6
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nores |-> (run_q < RW'(HOLD_LIMIT)));

endmodule

bind nvr_guard_seq nvr_guard_seq_chk #(.AW(AW), .HOLD_LIMIT(HOLD_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .pfail(pfail), .mem_we(mem_we),
  .mem_re(mem_re), .mem_busy(mem_busy), .nores(nores), .req_busy(req_busy),
  .mem_addr(mem_addr), .done(done)
);

// File: tb/nvr_guard_seq_test.sv
module nvr_guard_seq_test;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int LENW = 3;
  localparam int HOLD = 16;
  localparam int PARK = 63;
  localparam logic [7:0] VAL = 8'hA5;
  localparam logic [7:0] INV = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0, req_rd = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [LENW-1:0] req_len = '0;
  logic req_busy, in_ready, out_valid, done, rd_flag_ok, nores, mem_we, mem_re;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] out_data, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [1:0] done_status;
  logic pfail = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_busy;

  nvr_guard_seq uut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_rd(req_rd),
    .req_base(req_base), .req_len(req_len), .req_busy(req_busy),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .done(done),
    .done_status(done_status), .rd_flag_ok(rd_flag_ok), .pfail(pfail),
    .nores(nores), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .mem_busy(mem_busy)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Memory model
  logic [7:0] mem [64];
  bit mem_init = 1'b0;
  int bcnt = 0;
  int wcyc = 6;
  int kick_n = 0;
  logic we_s = 1'b0, re_s = 1'b0;
  logic [AW-1:0] addr_s = '0;
  logic [7:0] wd_s = '0;
  int wlog_a[$];
  int wlog_d[$];

  assign mem_busy = (bcnt != 0);

  always @(posedge clk) begin
    if (!mem_init) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h3C;
      mem_init <= 1'b1;
    end else if (we_s) begin
      mem[addr_s] <= wd_s;
    end
    if (we_s) begin
      wlog_a.push_back(int'(addr_s));
      wlog_d.push_back(int'(wd_s));
      bcnt <= wcyc;
    end else if (kick_n != 0) begin
      bcnt <= kick_n;
    end else if (bcnt > 0) begin
      bcnt <= bcnt - 1;
    end
    if (re_s) mem_rdata <= mem[addr_s];
  end

  // Payload feeder and power-fail driver
  logic [7:0] feed_q[$];
  bit hs = 1'b0;
  bit pf_force = 1'b0;
  bit pf_arm = 1'b0;
  int pf_at = 0;
  int strobes = 0;

  always @(posedge clk) begin
    #1;
    if (hs) void'(feed_q.pop_front());
    in_valid = (feed_q.size() > 0);
    in_data = (feed_q.size() > 0) ? feed_q[0] : 8'h00;
    pfail = pf_force || (pf_arm && strobes >= pf_at);
  end

  // Per-cycle monitor with behavioural expectations
  bit mon_on = 1'b0;
  bit prev_pf = 1'b0;
  bit wait_f = 1'b0;
  int run = 0;
  int max_run = 0;
  bit prev_done = 1'b0;

  always @(negedge clk) begin
    we_s = mem_we;
    re_s = mem_re;
    addr_s = mem_addr;
    wd_s = mem_wdata;
    hs = in_valid && in_ready;
    if (mon_on) begin
      bit raw;
      bit expn;
      raw = mem_we || wait_f;
      expn = raw && (run < HOLD);
      if (nores !== expn) chk(1'b0, "R5/R6 nores", int'(nores), int'(expn));
      else checks++;
      run = raw ? run + 1 : 0;
      if (nores) begin
        if (max_run < run) max_run = run;
      end
      if (mem_we) wait_f = 1'b1;
      else if (!mem_busy) wait_f = 1'b0;
      if (mem_we) begin
        strobes++;
        chk(!prev_pf, "R4 strobe after pfail", int'(prev_pf), 0);
        chk(!mem_busy, "R8 write while busy", int'(mem_busy), 0);
      end
      if (mem_re) chk(!mem_busy, "R8 read while busy", int'(mem_busy), 0);
      if (!req_busy) chk(int'(mem_addr) == PARK, "R7 park", int'(mem_addr), PARK);
      if (done && prev_done) chk(1'b0, "R11 done pulse", 1, 0);
      prev_done = done;
    end
    prev_pf = pfail;
  end

  task automatic start_op(input bit rd, input int base, input int len);
    @(posedge clk);
    #1;
    req_start = 1'b1;
    req_rd = rd;
    req_base = AW'(base);
    req_len = LENW'(len - 1);
    @(posedge clk);
    #1;
    req_start = 1'b0;
  endtask

  task automatic wait_done(output int st, output bit flag, output int got[$]);
    int n = 0;
    got = {};
    st = -1;
    flag = 1'b0;
    while (n < 2000) begin
      @(negedge clk);
      if (out_valid) got.push_back(int'(out_data));
      if (done) begin
        st = int'(done_status);
        flag = rd_flag_ok;
        break;
      end
      n++;
    end
    if (st < 0) chk(1'b0, "R11 done never seen", 0, 1);
  endtask

  function automatic logic [7:0] pat(input int base, input int i, input int seed);
    return 8'((base * 7 + i * 29 + seed * 53) & 255);
  endfunction

  // Full write of a record, expected to succeed.
  task automatic write_ok(input int base, input int len, input int seed, input bit poke);
    int st;
    bit fl;
    int got[$];
    wlog_a = {};
    wlog_d = {};
    for (int i = 0; i < len; i++) feed_q.push_back(pat(base, i, seed));
    start_op(1'b0, base, len);
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      req_start = 1'b1; req_rd = 1'b1; req_base = AW'(base + 5);
      @(posedge clk);
      #1;
      req_start = 1'b0;
    end
    wait_done(st, fl, got);
    chk(st == 0, "R2 status ok", st, 0);
    chk(wlog_a.size() == len + 2, "R2/R10/R11 strobe count", wlog_a.size(), len + 2);
    if (wlog_a.size() == len + 2) begin
      chk(wlog_a[0] == base && wlog_d[0] == int'(INV), "R2 flag cleared first", wlog_d[0], int'(INV));
      for (int i = 0; i < len; i++)
        chk(wlog_a[i + 1] == base + 1 + i && wlog_d[i + 1] == int'(pat(base, i, seed)),
            "R2 payload order", wlog_d[i + 1], int'(pat(base, i, seed)));
      chk(wlog_a[len + 1] == base && wlog_d[len + 1] == int'(VAL), "R2 flag set last",
          wlog_d[len + 1], int'(VAL));
    end
  endtask

  task automatic read_check(input int base, input int len, input bit exp_flag,
                            input int seed, input bit check_data);
    int st;
    bit fl;
    int got[$];
    start_op(1'b1, base, len);
    wait_done(st, fl, got);
    chk(st == 0, "R9 read status", st, 0);
    chk(fl == exp_flag, "R9 flag report", int'(fl), int'(exp_flag));
    chk(got.size() == len, "R9/R10 read count", got.size(), len);
    if (check_data && got.size() == len)
      for (int i = 0; i < len; i++)
        chk(got[i] == int'(pat(base, i, seed)), "R9 read data", got[i], int'(pat(base, i, seed)));
  endtask

  initial begin
    int st;
    bit fl;
    int got[$];
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state
    chk(!req_busy && !done && !mem_we && !mem_re, "R11 idle after reset", int'(req_busy), 0);
    chk(!nores, "R5 nores after reset", int'(nores), 0);
    chk(int'(mem_addr) == PARK, "R7 park after reset", int'(mem_addr), PARK);
    mon_on = 1'b1;

    write_ok(4, 3, 1, 1'b0);
    read_check(4, 3, 1'b1, 1, 1'b1);
    write_ok(20, 8, 2, 1'b0);
    read_check(20, 8, 1'b1, 2, 1'b1);
    write_ok(40, 1, 3, 1'b1);
    read_check(40, 1, 1'b1, 3, 1'b1);

    // R1: refused with power failing
    wlog_a = {};
    pf_force = 1'b1;
    feed_q.push_back(8'h11);
    feed_q.push_back(8'h22);
    start_op(1'b0, 10, 2);
    wait_done(st, fl, got);
    chk(st == 2, "R1 refused status", st, 2);
    chk(wlog_a.size() == 0, "R1 no strobe", wlog_a.size(), 0);
    chk(mem[10] == 8'h3C, "R1 flag cell untouched", int'(mem[10]), 'h3C);
    @(posedge clk); #1;
    pf_force = 1'b0;
    feed_q = {};
    repeat (2) @(posedge clk);

    // R3: power fails after the second strobe
    wlog_a = {};
    wlog_d = {};
    strobes = 0;
    pf_at = 2;
    pf_arm = 1'b1;
    for (int i = 0; i < 4; i++) feed_q.push_back(pat(30, i, 4));
    start_op(1'b0, 30, 4);
    wait_done(st, fl, got);
    chk(st == 1, "R3 abort status", st, 1);
    chk(wlog_a.size() == 2, "R3 strobe count", wlog_a.size(), 2);
    @(negedge clk);
    chk(mem[30] == INV, "R3 flag left invalid", int'(mem[30]), int'(INV));
    chk(mem[31] == pat(30, 0, 4), "R3 in-flight cell finished", int'(mem[31]), int'(pat(30, 0, 4)));
    chk(mem[32] == 8'h3C, "R3 later cell untouched", int'(mem[32]), 'h3C);
    @(posedge clk); #1;
    pf_arm = 1'b0;
    feed_q = {};
    repeat (2) @(posedge clk);
    read_check(30, 4, 1'b0, 4, 1'b0);

    // R8: memory busy on its own when the start arrives
    @(posedge clk); #1;
    kick_n = 12;
    @(posedge clk); #1;
    kick_n = 0;
    write_ok(50, 2, 5, 1'b0);
    @(posedge clk); #1;
    kick_n = 9;
    @(posedge clk); #1;
    kick_n = 0;
    read_check(50, 2, 1'b1, 5, 1'b1);

    // R6: programming time beyond the hold-off limit
    wcyc = 30;
    max_run = 0;
    write_ok(56, 1, 6, 1'b0);
    chk(max_run == HOLD, "R6 hold-off capped", max_run, HOLD);
    wcyc = 6;
    read_check(56, 1, 1'b1, 6, 1'b1);

    repeat (5) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule